// File: doc/BRIEF.md
# Up-Counting Timer with Slave-Mode Control

This block is a free-standing up-counter with a programmable prescaler and a reload limit. When the counter passes the limit it wraps to zero and raises a one-cycle update pulse. The update pulse can also be forwarded as an interrupt request. A 3-bit slave-mode field decides how the counting steps are produced. The counter can count the system clock, or count only while a trigger is high. It can be cleared or started by a trigger edge, it can be clocked by trigger edges, or it can follow a two-phase quadrature encoder in either direction.

A 3-bit trigger-select field picks one of eight trigger candidates: four internal triggers, the channel-1 edge-detect signal, filtered channel 1, filtered channel 2 and the filtered external trigger. All candidates arrive already filtered and synchronised to `clk`. A separate enable switches the counting source to rising edges of the filtered external trigger, and it combines with the non-encoder modes. Software starts and stops the counter with single-cycle pulses.

Top module: `slave_timer`

## Requirements
- R1: While reset is applied, and until the first qualifying event after it, `count` is 0 and `update`, `irq` and `running` are 0.
- R2: Outside the encoder modes (mode 001, 010, 011), a `sw_start` pulse sets `running` at the next edge and a `sw_stop` pulse clears it; `sw_stop` wins over any set. While `running` is 0 in modes 000, 101, 110 and 111, `count` holds.
- R3: Each counting step is delivered through a prescaler, so `count` advances once per `presc`+1 counting steps.
- R4: Counting up from a value at or above `reload`, the counter goes to 0 and `update` is 1 for exactly that cycle. At all other times `update` is 0 except as given in R12.
- R5: `irq` equals `update` when `irq_en` was 1 at that edge, and `irq` is 0 otherwise.
- R6: `tsel` picks the trigger: 000 to 011 select `itr[0]` to `itr[3]`, 100 selects `ch1_edge`, 101 selects `ch1_filt`, 110 selects `ch2_filt`, and 111 selects `ext_filt`. Unselected candidates have no effect.
- R7: In mode 100 (reset), a rising edge of the selected trigger clears both the counter and the prescaler at that edge, whether or not the counter is running. The clear takes priority over counting and gives no update.
- R8: In mode 101 (gated), a counting step is taken only in cycles where the selected trigger is high and `running` is 1.
- R9: In mode 110 (trigger), a rising edge of the selected trigger sets `running`, unless `sw_stop` is present in the same cycle.
- R10: In mode 111 (external clock 1), while `running` is 1, each rising edge of the selected trigger is one counting step.
- R11: With `xclk2_en` set in modes 000, 100, 101 and 110, the counting steps are the rising edges of `ext_filt` instead of every cycle. Gating (R8) still applies.
- R12: In the encoder modes, mode 001 steps on `ch2_filt` changes, mode 010 steps on `ch1_filt` changes, and mode 011 steps on both. A change on both channels in the same cycle is ignored.
  - A `ch1_filt` change counts up when the new `ch1_filt` differs from `ch2_filt`. A `ch2_filt` change counts up when the new `ch2_filt` equals `ch1_filt`. All other valid changes count down.
  - Encoder steps bypass the prescaler and `running`.
  - Counting down from 0 loads `reload` and pulses `update`.
  - `sw_start` and `sw_stop` are ignored, and `running` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Slave-mode field |
| tsel | input | 3 | Trigger-select field |
| xclk2_en | input | 1 | Count on rising edges of `ext_filt` |
| irq_en | input | 1 | Update interrupt enable |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| presc | input | 16 | Prescaler value (divide by value+1) |
| reload | input | 16 | Reload limit |
| itr | input | 4 | Internal triggers 0..3 |
| ch1_edge | input | 1 | Channel-1 edge-detect signal |
| ch1_filt | input | 1 | Filtered channel 1 |
| ch2_filt | input | 1 | Filtered channel 2 |
| ext_filt | input | 1 | Filtered external trigger |
| count | output | 16 | Counter value |
| update | output | 1 | Update event pulse |
| irq | output | 1 | Update interrupt request |
| running | output | 1 | Counter-enable state |

## Verification
Any wrong internal state shows up on `count` or `running` within one counting step.
- A prescaler phase error moves the next increment by at least one cycle.
- A stale trigger-history flop produces a clear, a start or a step one edge early or late, or a missing or extra one.
- A wrong encoder direction moves `count` the wrong way on the very next channel change.

A reference model in the bench runs in step with the design and compares all four outputs after every edge, so each of these faults is reported in the cycle where it first appears.

// File: rtl/slave_timer_pkg.sv
package slave_timer_pkg;

  typedef enum logic [2:0] {
    SM_FREE   = 3'd0,
    SM_ENC_B  = 3'd1,
    SM_ENC_A  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_TRIG   = 3'd6,
    SM_XCLK   = 3'd7
  } slave_mode_e;

  // Fixed trigger candidates besides the internal ones
  localparam int unsigned FIXED_SRC = 4;

  function automatic logic is_encoder(input slave_mode_e m);
    return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_AB);
  endfunction

endpackage

// File: rtl/slave_timer_sel.sv
module slave_timer_sel
  import slave_timer_pkg::*;
#(
  parameter int unsigned NUM_ITR = 4,
  localparam int unsigned NUM_SRC = NUM_ITR + FIXED_SRC,
  localparam int unsigned SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   tsel,
  input  logic [NUM_ITR-1:0] itr,
  input  logic               ch1_edge,
  input  logic               ch1_filt,
  input  logic               ch2_filt,
  input  logic               ext_filt,
  output logic               trg_lvl,
  output logic               trg_rise,
  output logic               ext_rise,
  output logic               a_chg,
  output logic               b_chg
);

  localparam int unsigned NOBS = 4;

  logic [NUM_SRC-1:0] src;
  logic [NOBS-1:0]    obs, obs_q, rise, chg;

  assign src = {ext_filt, ch2_filt, ch1_filt, ch1_edge, itr};

  always_comb begin
    trg_lvl = src[tsel];
  end

  // Observed lines: 0 selected trigger, 1 external, 2 channel 1, 3 channel 2
  assign obs = {ch2_filt, ch1_filt, ext_filt, trg_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obs_q <= '0;
    else        obs_q <= obs;
  end

  for (genvar g = 0; g < NOBS; g++) begin : g_edge
    assign rise[g] = obs[g] & ~obs_q[g];
    assign chg[g]  = obs[g] ^ obs_q[g];
  end

  assign trg_rise = rise[0];
  assign ext_rise = rise[1];
  assign a_chg    = chg[2];
  assign b_chg    = chg[3];

endmodule

// File: rtl/slave_timer_slave.sv
module slave_timer_slave
  import slave_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       xclk2_en,
  input  logic       sw_start,
  input  logic       sw_stop,
  input  logic       trg_lvl,
  input  logic       trg_rise,
  input  logic       ext_rise,
  input  logic       a_chg,
  input  logic       b_chg,
  input  logic       a_lvl,
  input  logic       b_lvl,
  output logic       tick,
  output logic       clear,
  output logic       enc_step,
  output logic       enc_up,
  output logic       running
);

  slave_mode_e m;
  logic        enc, base, run_q, run_d, run_ce, step_a, step_b;

  assign m   = slave_mode_e'(mode);
  assign enc = is_encoder(m);

  // Counting source before gating
  assign base = xclk2_en ? ext_rise : 1'b1;

  always_comb begin
    tick  = 1'b0;
    clear = 1'b0;
    case (m)
      SM_XCLK:  tick = run_q & trg_rise;
      SM_GATED: tick = run_q & base & trg_lvl;
      SM_RESET: begin
        tick  = run_q & base;
        clear = trg_rise;
      end
      SM_ENC_A, SM_ENC_B, SM_ENC_AB: tick = 1'b0;
      default:  tick = run_q & base;
    endcase
  end

  // Quadrature stepping: simultaneous changes are discarded
  assign step_a   = a_chg & ~b_chg & ((m == SM_ENC_A) | (m == SM_ENC_AB));
  assign step_b   = b_chg & ~a_chg & ((m == SM_ENC_B) | (m == SM_ENC_AB));
  assign enc_step = step_a | step_b;
  assign enc_up   = step_a ? (a_lvl ^ b_lvl) : ~(a_lvl ^ b_lvl);

  always_comb begin
    run_d  = run_q;
    run_ce = 1'b0;
    if (!enc) begin
      if (sw_stop) begin
        run_d  = 1'b0;
        run_ce = 1'b1;
      end else if (sw_start || (m == SM_TRIG && trg_rise)) begin
        run_d  = 1'b1;
        run_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_ce) run_q <= run_d;
  end

  assign running = run_q;

endmodule

// File: rtl/slave_timer_core.sv
module slave_timer_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] presc,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             tick,
  input  logic             clear,
  input  logic             enc_step,
  input  logic             enc_up,
  output logic [CNT_W-1:0] count,
  output logic             update,
  output logic             irq
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] pre_q, pre_d;
  logic             upd_q, upd_d, irq_q, irq_d, ce;
  logic             top_hit, zero_hit;

  assign top_hit  = (cnt_q >= reload);
  assign zero_hit = (cnt_q == '0);
  assign ce       = clear | enc_step | tick;

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    upd_d = 1'b0;
    if (clear) begin
      cnt_d = '0;
      pre_d = '0;
    end else if (enc_step) begin
      if (enc_up) begin
        if (top_hit) begin
          cnt_d = '0;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (zero_hit) begin
          cnt_d = reload;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end else if (tick) begin
      if (pre_q >= presc) begin
        pre_d = '0;
        if (top_hit) begin
          cnt_d = '0;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    irq_d = upd_d & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (ce) begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
      irq_q <= irq_d;
    end
  end

  assign count  = cnt_q;
  assign update = upd_q;
  assign irq    = irq_q;

endmodule

// File: rtl/slave_timer.sv
module slave_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned NUM_ITR = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_ITR + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mode,
  input  logic [SEL_W-1:0]   tsel,
  input  logic               xclk2_en,
  input  logic               irq_en,
  input  logic               sw_start,
  input  logic               sw_stop,
  input  logic [PSC_W-1:0]   presc,
  input  logic [CNT_W-1:0]   reload,
  input  logic [NUM_ITR-1:0] itr,
  input  logic               ch1_edge,
  input  logic               ch1_filt,
  input  logic               ch2_filt,
  input  logic               ext_filt,
  output logic [CNT_W-1:0]   count,
  output logic               update,
  output logic               irq,
  output logic               running
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       trg_lvl, trg_rise, ext_rise, a_chg, b_chg;
  logic       tick, clear, enc_step, enc_up;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  slave_timer_sel #(.NUM_ITR(NUM_ITR)) u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tsel     (tsel),
    .itr      (itr),
    .ch1_edge (ch1_edge),
    .ch1_filt (ch1_filt),
    .ch2_filt (ch2_filt),
    .ext_filt (ext_filt),
    .trg_lvl  (trg_lvl),
    .trg_rise (trg_rise),
    .ext_rise (ext_rise),
    .a_chg    (a_chg),
    .b_chg    (b_chg)
  );

  slave_timer_slave u_slave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode     (mode),
    .xclk2_en (xclk2_en),
    .sw_start (sw_start),
    .sw_stop  (sw_stop),
    .trg_lvl  (trg_lvl),
    .trg_rise (trg_rise),
    .ext_rise (ext_rise),
    .a_chg    (a_chg),
    .b_chg    (b_chg),
    .a_lvl    (ch1_filt),
    .b_lvl    (ch2_filt),
    .tick     (tick),
    .clear    (clear),
    .enc_step (enc_step),
    .enc_up   (enc_up),
    .running  (running)
  );

  slave_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .presc    (presc),
    .reload   (reload),
    .irq_en   (irq_en),
    .tick     (tick),
    .clear    (clear),
    .enc_step (enc_step),
    .enc_up   (enc_up),
    .count    (count),
    .update   (update),
    .irq      (irq)
  );

endmodule

// File: rtl/slave_timer_chk.sv
module slave_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic [SEL_W-1:0] tsel,
  input logic             sw_stop,
  input logic             ext_filt,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             update,
  input logic             irq,
  input logic             running
);

  logic enc;
  assign enc = (mode != 3'd0) && (mode <= 3'd3);

  // R5
  irq_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> update);

  // R4
  update_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> (count == '0 || count == $past(reload)));

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc && sw_stop) |=> !running);

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && (mode == 3'd0 || mode == 3'd5 || mode == 3'd6 || mode == 3'd7))
      |=> $stable(count));

  // R12
  enc_run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc |=> $stable(running));

  // R9
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6 && tsel == SEL_W'(7) && $past(tsel) == SEL_W'(7) &&
     $rose(ext_filt) && !sw_stop) |=> running);

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && tsel == SEL_W'(7) && $past(tsel) == SEL_W'(7) &&
     $rose(ext_filt)) |=> (count == '0));

endmodule

bind slave_timer slave_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mode     (mode),
  .tsel     (tsel),
  .sw_stop  (sw_stop),
  .ext_filt (ext_filt),
  .reload   (reload),
  .count    (count),
  .update   (update),
  .irq      (irq),
  .running  (running)
);

// File: tb/slave_timer_bench.sv
module slave_timer_bench;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode, tsel;
  logic        xclk2_en, irq_en, sw_start, sw_stop;
  logic [15:0] presc, reload;
  logic [3:0]  itr;
  logic        ch1_edge, ch1_filt, ch2_filt, ext_filt;
  logic [15:0] count;
  logic        update, irq, running;

  int n_chk;
  int n_fail;

  // Reference state
  logic [15:0] m_cnt, m_pcnt;
  logic        m_run, m_upd, m_irq, m_trg_q, m_ext_q, m_a_q, m_b_q;

  slave_timer u_slave_timer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tsel(tsel), .xclk2_en(xclk2_en),
    .irq_en(irq_en), .sw_start(sw_start), .sw_stop(sw_stop), .presc(presc),
    .reload(reload), .itr(itr), .ch1_edge(ch1_edge), .ch1_filt(ch1_filt),
    .ch2_filt(ch2_filt), .ext_filt(ext_filt), .count(count), .update(update),
    .irq(irq), .running(running)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string mode_tag();
    case (mode)
      3'd0:    return xclk2_en ? "R11" : "R2";
      3'd1, 3'd2, 3'd3: return "R12";
      3'd4:    return "R7";
      3'd5:    return "R8";
      3'd6:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_pcnt = '0; m_run = 0; m_upd = 0; m_irq = 0;
    m_trg_q = 0; m_ext_q = 0; m_a_q = 0; m_b_q = 0;
  endtask

  task automatic cnt_up();
    if (m_cnt >= reload) begin m_cnt = '0; m_upd = 1'b1; end
    else m_cnt = m_cnt + 16'd1;
  endtask

  // Reference for one clock edge, built from the requirements
  task automatic model_edge();
    logic [7:0] src;
    logic sel, t_rise, e_rise, a_chg, b_chg, enc, base, tick, clr, sa, sb, up;
    src    = {ext_filt, ch2_filt, ch1_filt, ch1_edge, itr};
    sel    = src[tsel];
    t_rise = sel & ~m_trg_q;
    e_rise = ext_filt & ~m_ext_q;
    a_chg  = ch1_filt ^ m_a_q;
    b_chg  = ch2_filt ^ m_b_q;
    enc    = (mode >= 3'd1 && mode <= 3'd3);
    base   = xclk2_en ? e_rise : 1'b1;
    if (mode == 3'd7)      tick = m_run & t_rise;
    else if (mode == 3'd5) tick = m_run & base & sel;
    else                   tick = !enc & m_run & base;
    clr = (mode == 3'd4) && t_rise;
    sa  = enc && a_chg && !b_chg && mode != 3'd1;
    sb  = enc && b_chg && !a_chg && mode != 3'd2;
    up  = sa ? (ch1_filt != ch2_filt) : (ch2_filt == ch1_filt);
    m_upd = 1'b0;
    if (clr) begin
      m_cnt = '0; m_pcnt = '0;
    end else if (sa || sb) begin
      if (up) cnt_up();
      else if (m_cnt == 16'd0) begin m_cnt = reload; m_upd = 1'b1; end
      else m_cnt = m_cnt - 16'd1;
    end else if (tick) begin
      if (m_pcnt >= presc) begin m_pcnt = '0; cnt_up(); end
      else m_pcnt = m_pcnt + 16'd1;
    end
    m_irq = m_upd & irq_en;
    if (!enc) begin
      if (sw_stop) m_run = 1'b0;
      else if (sw_start || (mode == 3'd6 && t_rise)) m_run = 1'b1;
    end
    m_trg_q = sel; m_ext_q = ext_filt; m_a_q = ch1_filt; m_b_q = ch2_filt;
  endtask

  task automatic step();
    string t;
    t = mode_tag();
    model_edge();
    @(posedge clk);
    #1;
    chk({t, " count"}, 32'(count), 32'(m_cnt));
    chk({t, " update"}, 32'(update), 32'(m_upd));
    chk({t, " irq"}, 32'(irq), 32'(m_irq));
    chk({t, " running"}, 32'(running), 32'(m_run));
    @(negedge clk);
  endtask

  task automatic set_src(input int idx, input logic v);
    case (idx)
      0, 1, 2, 3: itr[idx] = v;
      4: ch1_edge = v;
      5: ch1_filt = v;
      6: ch2_filt = v;
      default: ext_filt = v;
    endcase
  endtask

  function automatic logic [1:0] gray(input logic [1:0] ph);
    case (ph)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] qph;
    logic [15:0] held;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; mode = 0; tsel = 0; xclk2_en = 0; irq_en = 0;
    sw_start = 0; sw_stop = 0; presc = 0; reload = 16'd100; itr = 0;
    ch1_edge = 0; ch1_filt = 0; ch2_filt = 0; ext_filt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 update", 32'(update), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 running", 32'(running), 0);
    rst_n = 1;
    repeat (3) step();

    // R3/R4/R5: prescale by 3, reload 3
    presc = 16'd2; reload = 16'd3; irq_en = 1;
    sw_start = 1; step(); sw_start = 0;
    repeat (11) step();
    chk("R3 count after 11", 32'(count), 3);
    chk("R3 no update", 32'(update), 0);
    step();
    chk("R4 wrap count", 32'(count), 0);
    chk("R4 update pulse", 32'(update), 1);
    chk("R5 irq enabled", 32'(irq), 1);
    irq_en = 0;
    repeat (12) step();
    chk("R4 second wrap", 32'(update), 1);
    chk("R5 irq masked", 32'(irq), 0);
    // R2 stop wins
    sw_start = 1; sw_stop = 1; step(); sw_start = 0; sw_stop = 0;
    chk("R2 stop wins", 32'(running), 0);
    held = count;
    repeat (5) step();
    chk("R2 hold while stopped", 32'(count), 32'(held));

    // R6 trigger selection in reset mode
    mode = 3'd4; presc = 0; reload = 16'd200;
    sw_start = 1; step(); sw_start = 0;
    for (int k = 0; k < 8; k++) begin
      tsel = 3'(k);
      repeat (4) step();
      set_src((k + 1) % 8, 1'b1); step();
      chk("R6 unselected no clear", 32'(count != 0), 1);
      set_src(k, 1'b1); step();
      chk("R6 selected clears (R7)", 32'(count), 0);
      set_src(k, 1'b0); set_src((k + 1) % 8, 1'b0); step();
    end

    // R12 software pulses ignored in encoder mode
    mode = 3'd1; sw_stop = 1; step(); sw_stop = 0;
    chk("R12 stop ignored", 32'(running), 1);
    // R12 down wrap from zero
    mode = 3'd4; tsel = 3'd7; sw_stop = 1; ext_filt = 1; step();
    ext_filt = 0; sw_stop = 0; step();
    chk("R7 cleared", 32'(count), 0);
    mode = 3'd3; reload = 16'd5; ch2_filt = 1; step();
    chk("R12 down wrap count", 32'(count), 5);
    chk("R12 down wrap update", 32'(update), 1);
    ch1_filt = 1; step();
    chk("R12 down step", 32'(count), 4);

    // Constrained random phases across every mode
    for (int c = 0; c < 48; c++) begin
      mode     = 3'(c % 8);
      tsel     = 3'($urandom % 8);
      presc    = 16'($urandom % 4);
      reload   = 16'($urandom % 10);
      xclk2_en = (($urandom % 3) == 0);
      irq_en   = 1'($urandom % 2);
      case ({ch1_filt, ch2_filt})
        2'b00: qph = 2'd0;
        2'b10: qph = 2'd1;
        2'b11: qph = 2'd2;
        default: qph = 2'd3;
      endcase
      for (int n = 0; n < 250; n++) begin
        int r;
        sw_start = (($urandom % 20) == 0);
        sw_stop  = (($urandom % 60) == 0);
        if (mode >= 3'd1 && mode <= 3'd3) begin
          r = int'($urandom % 8);
          if (r < 3)       qph = qph + 2'd1;
          else if (r < 5)  qph = qph - 2'd1;
          else if (r == 5) qph = qph + 2'd2;
          {ch1_filt, ch2_filt} = gray(qph);
          for (int s = 0; s < 4; s++)
            if (($urandom % 6) == 0) itr[s] = ~itr[s];
        end else begin
          for (int s = 0; s < 8; s++)
            if (($urandom % 6) == 0) begin
              case (s)
                0, 1, 2, 3: itr[s] = ~itr[s];
                4: ch1_edge = ~ch1_edge;
                5: ch1_filt = ~ch1_filt;
                6: ch2_filt = ~ch2_filt;
                default: ext_filt = ~ext_filt;
              endcase
            end
        end
        step();
      end
      sw_start = 0; sw_stop = 0;
    end
    finish_run();
  end

endmodule